// File: doc/BRIEF.md
# Extended Peripheral Select Decoder

This block bridges the I/O bus of an 8-bit microcontroller and a programmable-logic fabric. Four consecutive I/O addresses each name a group of four fabric select lines. A two-bit line field, held in a small control register, picks one line inside the group. Any access to one of the four group addresses therefore drives exactly one of sixteen select lines high. In the same cycle it raises a qualified read or write strobe toward the fabric. The fabric's own registers use the select line and the strobe together.

The control register sits at its own I/O address. It holds a flag bit and the line field. Software writes the field before it touches the group address. The new field is used from the cycle after that write.

While reset is held, the block raises every select line and the write strobe, and it keeps the read strobe low. Every fabric register that listens can then capture the data bus, which the bus holds at 0x00, and so start from zero. The bus side uses plain enable strobes with no valid/ready handshake. The block never stalls an access, so it has no back-pressure. Selects and strobes are combinational from the current address, the enables and the stored field.

Top module: `fabric_sel_decoder`

## Requirements
- R1: Outside reset, a read or write at group address 0x14+g (g = 0..3) drives select line g*4+f high and all other lines low, where f is control bits [1:0].
- R2: Outside reset, with no enable high or with an address outside 0x14..0x17, all sixteen select lines are low.
- R3: Outside reset, the fabric read strobe equals the bus read enable ANDed with a hit on any of the four group addresses.
- R4: Outside reset, the fabric write strobe equals the bus write enable ANDed with a hit on any of the four group addresses.
- R5: A write at control address 0x13 stores data bit 7 as the flag and data bits [1:0] as the field, and the new field is used from the next cycle. A write to any other address leaves both unchanged.
- R6: A read at 0x13 returns {flag, 5'b00000, field} on the control read data, so bits 6..2 are always zero. The read data is 0x00 in every other cycle.
- R7: While reset is low, all sixteen select lines are high, the write strobe is high and the read strobe is low. Reset also clears the flag and the field to zero.
- R8: After reset is released, the select lines return to all zero until the next qualified access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; forces the fabric clearing pattern |
| io_addr | input | 6 | I/O address of the current access |
| io_rd | input | 1 | Bus read enable |
| io_wr | input | 1 | Bus write enable |
| io_wdata | input | 8 | Bus write data |
| sel | output | 16 | One-hot fabric select lines (all high during reset) |
| fab_rd | output | 1 | Qualified read strobe to the fabric |
| fab_wr | output | 1 | Qualified write strobe to the fabric |
| ctl_rdata | output | 8 | Control register read data |

## Verification
Reset and a bus access can fall in the same cycle. The bench holds a read enable on a group address while reset is low and judges that the clearing pattern wins: all lines high, write strobe high, read strobe low. A field update and its first use fall in adjacent cycles. The bench writes the field and then sweeps every group address with both enables, computing the expected line as g*4+f.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int unsigned DATA_W = 8;

  function automatic logic [DATA_W-1:0] pack_ctl(input logic flag, input logic [1:0] fld);
    logic [DATA_W-1:0] v;
    v = '0;
    v[DATA_W-1] = flag;
    v[1:0] = fld;
    return v;
  endfunction
endpackage

// File: rtl/fsd_group_match.sv
module fsd_group_match #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NUM_GRP = 4,
  parameter logic [ADDR_W-1:0] GRP_BASE = 6'h14,
  localparam int unsigned GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [GRP_W-1:0]  grp
);
  logic [NUM_GRP-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_cmp
      localparam logic [ADDR_W-1:0] ADDR_G = ADDR_W'(GRP_BASE + g);
      assign hit_vec[g] = (addr == ADDR_G);
    end
  endgenerate

  always_comb begin
    grp = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      if (hit_vec[i]) grp = GRP_W'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/fsd_ctl_reg.sv
module fsd_ctl_reg
  import fsd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [1:0]        field_q,
  output logic [DATA_W-1:0] rdata
);
  logic flag_q;
  logic hit;

  assign hit = (addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      field_q <= 2'b00;
    end else if (wr && hit) begin
      flag_q  <= wdata[DATA_W-1];
      field_q <= wdata[1:0];
    end
  end

  assign rdata = (rd && hit) ? pack_ctl(flag_q, field_q) : '0;
endmodule

// File: rtl/fsd_line_dec.sv
module fsd_line_dec #(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned LINES_PER_GRP = 4,
  localparam int unsigned GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned FLD_W = (LINES_PER_GRP > 1) ? $clog2(LINES_PER_GRP) : 1,
  localparam int unsigned NUM_SEL = NUM_GRP * LINES_PER_GRP
) (
  input  logic               en,
  input  logic               force_all,
  input  logic [GRP_W-1:0]   grp,
  input  logic [FLD_W-1:0]   fld,
  output logic [NUM_SEL-1:0] sel
);
  genvar gi, li;
  generate
    for (gi = 0; gi < NUM_GRP; gi++) begin : g_grp
      for (li = 0; li < LINES_PER_GRP; li++) begin : g_line
        assign sel[gi*LINES_PER_GRP + li] =
          force_all | (en & (grp == GRP_W'(gi)) & (fld == FLD_W'(li)));
      end
    end
  endgenerate
endmodule

// File: rtl/fabric_sel_decoder.sv
module fabric_sel_decoder
  import fsd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] GRP_BASE = 6'h14,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [15:0]       sel,
  output logic              fab_rd,
  output logic              fab_wr,
  output logic [7:0]        ctl_rdata
);
  localparam int unsigned NUM_GRP = 4;
  localparam int unsigned LINES_PER_GRP = 4;
  localparam int unsigned GRP_W = $clog2(NUM_GRP);

  logic             grp_hit;
  logic [GRP_W-1:0] grp_idx;
  logic [1:0]       field_q;

  fsd_group_match #(
    .ADDR_W  (ADDR_W),
    .NUM_GRP (NUM_GRP),
    .GRP_BASE(GRP_BASE)
  ) u_match (
    .addr(io_addr),
    .hit (grp_hit),
    .grp (grp_idx)
  );

  fsd_ctl_reg #(
    .ADDR_W  (ADDR_W),
    .CTL_ADDR(CTL_ADDR)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (io_addr),
    .rd     (io_rd),
    .wr     (io_wr),
    .wdata  (io_wdata),
    .field_q(field_q),
    .rdata  (ctl_rdata)
  );

  fsd_line_dec #(
    .NUM_GRP      (NUM_GRP),
    .LINES_PER_GRP(LINES_PER_GRP)
  ) u_dec (
    .en       ((io_rd | io_wr) & grp_hit),
    .force_all(~rst_n),
    .grp      (grp_idx),
    .fld      (field_q),
    .sel      (sel)
  );

  assign fab_rd = rst_n & io_rd & grp_hit;
  assign fab_wr = ~rst_n | (io_wr & grp_hit);
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] GRP_BASE = 6'h14,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [15:0]       sel,
  input logic              fab_rd,
  input logic              fab_wr,
  input logic [1:0]        field_q
);
  logic [ADDR_W-1:0] rel;
  logic [3:0]        line_idx;
  logic              ctl_we;

  assign rel      = io_addr - GRP_BASE;
  assign line_idx = {rel[1:0], field_q};
  assign ctl_we   = io_wr && (io_addr == CTL_ADDR);

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_rd || fab_wr) |-> ($countones(sel) == 1)); // R1

  AST_RIGHT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_rd || fab_wr) |-> sel[line_idx]); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!fab_rd && !fab_wr) |-> (sel == 16'h0000)); // R2

  AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fab_rd |-> io_rd); // R3

  AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fab_wr |-> io_wr); // R4

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(field_q)); // R5

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_CLEAR: assert ((sel == 16'hFFFF) && fab_wr && !fab_rd); // R7
    end
  end
endmodule

bind fabric_sel_decoder fsd_checker #(
  .ADDR_W  (ADDR_W),
  .GRP_BASE(GRP_BASE),
  .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .io_addr(io_addr),
  .io_rd  (io_rd),
  .io_wr  (io_wr),
  .sel    (sel),
  .fab_rd (fab_rd),
  .fab_wr (fab_wr),
  .field_q(field_q)
);

// File: tb/fabric_sel_decoder_tb.sv
`timescale 1ns/1ps
module fabric_sel_decoder_tb;
  logic        clk;
  logic        rst_n;
  logic [5:0]  io_addr;
  logic        io_rd;
  logic        io_wr;
  logic [7:0]  io_wdata;
  logic [15:0] sel;
  logic        fab_rd;
  logic        fab_wr;
  logic [7:0]  ctl_rdata;

  int n_chk;
  int n_fail;

  fabric_sel_decoder u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .sel      (sel),
    .fab_rd   (fab_rd),
    .fab_wr   (fab_wr),
    .ctl_rdata(ctl_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    io_rd = 1'b0;
    io_wr = 1'b0;
    io_addr = 6'h00;
    io_wdata = 8'h00;
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    io_addr = 6'h13;
    io_wr = 1'b1;
    io_rd = 1'b0;
    io_wdata = v;
    @(negedge clk);
    io_wr = 1'b0;
    io_wdata = 8'h00;
  endtask

  task automatic ctl_read_check(input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = 6'h13;
    io_rd = 1'b1;
    io_wr = 1'b0;
    #2;
    check(ctl_rdata == exp, req, ctl_rdata, exp);
    io_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    io_addr = 6'h14;
    io_rd = 1'b1;
    io_wr = 1'b0;
    io_wdata = 8'h00;
    #3;
    // R7: the clearing pattern wins over a read in the same cycle
    check(sel == 16'hFFFF, "R7 sel in reset", sel, 16'hFFFF);
    check(fab_wr == 1'b1, "R7 write strobe in reset", fab_wr, 1);
    check(fab_rd == 1'b0, "R7 read strobe in reset", fab_rd, 0);
    repeat (3) @(posedge clk);
    idle();
    rst_n = 1'b1;
    #2;
    check(sel == 16'h0000, "R8 sel after release", sel, 0);
    check(fab_wr == 1'b0, "R8 write strobe after release", fab_wr, 0);
    ctl_read_check(8'h00, "R7 control cleared");

    // R1 R3 R4 R5 R6: sweep every field value against every group
    for (int f = 0; f < 4; f++) begin
      logic [7:0] wv;
      wv = 8'h7C | 8'(f) | ((f % 2 == 1) ? 8'h80 : 8'h00);
      ctl_write(wv);
      ctl_read_check({wv[7], 5'b00000, wv[1:0]}, "R6 readback reserved zero / R5 store");
      for (int g = 0; g < 4; g++) begin
        for (int op = 0; op < 2; op++) begin
          logic [15:0] exp_sel;
          exp_sel = 16'h0001 << (g * 4 + f);
          @(negedge clk);
          io_addr = 6'(6'h14 + g);
          io_rd = (op == 0);
          io_wr = (op == 1);
          io_wdata = 8'h5A;
          #2;
          check(sel == exp_sel, "R1 selected line", sel, exp_sel);
          check(fab_rd == (op == 0), "R3 read strobe", fab_rd, (op == 0));
          check(fab_wr == (op == 1), "R4 write strobe", fab_wr, (op == 1));
          check(ctl_rdata == 8'h00, "R6 no readback off address", ctl_rdata, 0);
        end
      end
      idle();
      #2;
      check(sel == 16'h0000, "R2 no enable", sel, 0);
    end

    // R5: writes elsewhere leave the field alone
    ctl_write(8'h01);
    @(negedge clk);
    io_addr = 6'h16;
    io_wr = 1'b1;
    io_wdata = 8'h83;
    @(negedge clk);
    io_wr = 1'b0;
    ctl_read_check(8'h01, "R5 foreign write ignored");
    @(negedge clk);
    io_addr = 6'h15;
    io_rd = 1'b1;
    #2;
    check(sel == 16'h0020, "R5 field kept for select", sel, 16'h0020);
    idle();

    // R2 R3 R4: every other address with both enables
    for (int a = 0; a < 64; a++) begin
      if (a >= 8'h14 && a <= 8'h17) continue;
      for (int op = 0; op < 2; op++) begin
        @(negedge clk);
        io_addr = 6'(a);
        io_rd = (op == 0);
        io_wr = 1'b0;
        io_wdata = 8'h00;
        if (op == 1 && a != 8'h13) io_wr = 1'b1;
        #2;
        check(sel == 16'h0000, "R2 non-group address", sel, 0);
        check(fab_rd == 1'b0, "R3 read strobe unqualified", fab_rd, 0);
        check(fab_wr == 1'b0, "R4 write strobe unqualified", fab_wr, 0);
      end
    end
    idle();

    // R7: reset mid-run clears flag and field
    ctl_write(8'h83);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(sel == 16'hFFFF, "R7 sel on second reset", sel, 16'hFFFF);
    check(fab_wr == 1'b1, "R7 write strobe on second reset", fab_wr, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(sel == 16'h0000, "R8 sel after second release", sel, 0);
    ctl_read_check(8'h00, "R7 control cleared again");
    @(negedge clk);
    io_rd = 1'b0;
    io_addr = 6'h17;
    io_wr = 1'b1;
    #2;
    check(sel == 16'h1000, "R1 group three with cleared field", sel, 16'h1000);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule